// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits between the header decoder of a CAN receiver and its receive FIFO. Once the header of a standard-format (11-bit identifier) frame has been taken in, the decoder raises a one-cycle header-complete strobe. At the same time it presents the identifier, the remote-request bit, the data length code and the first two data bytes. The filter lines these fields up against a 32-bit acceptance pattern and answers one clock later with a single-cycle accept pulse. That pulse gates the write into the FIFO. Frames that do not match are dropped silently.

The pattern is a code/mask pair, and each half is held as four byte-wide registers. Where a mask bit is one, that position is don't-care. Where a mask bit is zero, the received bit must equal the code bit. A small host write port loads the registers, and it is open only while the configuration-mode input is high. After reset every mask bit is one, so the filter passes all traffic until it is programmed.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is applied and after reset is released, `accept` is low. After reset all mask registers hold 0xFF and all code registers hold 0x00, so every frame is accepted until the host programs the registers.
- R2: When `cfg_mode`=1 and `wr_en`=1, the write loads `wr_data` on the clock edge. Address bit 2 selects the bank (0 = code, 1 = mask) and address bits 1:0 select byte 0 to 3.
- R3: A write made while `cfg_mode`=0 is ignored and leaves both banks unchanged.
- R4: For every compared position, a mask bit of 1 makes that position don't-care. A mask bit of 0 requires the received bit to equal the code bit. The frame is accepted only if every compared position passes.
- R5: Byte 0 covers identifier bits 10..3, with bit 7 holding identifier bit 10. Byte 1 bits 7..5 cover identifier bits 2..0, with bit 7 holding identifier bit 2.
- R6: Byte 1 bit 4 is compared with the remote-request bit. Byte 1 bits 3..0 are never compared. A mask byte 1 of 0x1F therefore ignores the remote-request bit and the unused bits.
- R7: Byte 2 is compared with the first data byte (`rx_data[7:0]`) and byte 3 with the second data byte (`rx_data[15:8]`), whenever those bytes are present in the frame.
- R8: Data bytes that the frame does not carry are don't-care. With a length code of 0 both bytes 2 and 3 are ignored. With a length code of 1 byte 3 is ignored. A remote frame (`rx_rtr`=1) ignores both bytes whatever its length code.
- R9: `accept` is high for exactly the one cycle after the edge that samples `hdr_done`=1 with a passing frame. It is low in every other cycle.
- R10: With all four mask bytes at 0xFF, every frame is accepted whatever the code values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | High while the controller is in configuration mode; opens the write port |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Bit 2: bank (0 code, 1 mask); bits 1:0: byte index |
| wr_data | input | 8 | Write data |
| rx_id | input | 11 | Received standard identifier |
| rx_rtr | input | 1 | Received remote-request bit |
| rx_dlc | input | 4 | Received data length code |
| rx_data | input | 16 | First two received data bytes, first byte in bits 7:0 |
| hdr_done | input | 1 | One-cycle strobe: header fields valid |
| accept | output | 1 | One-cycle pulse: store this frame |

## Verification
The bench builds the filter with its default parameters: 8-bit bytes, four pattern bytes, an 11-bit identifier and a pass-all mask reset. These values give it the reset pass-all state and the full 4-bit length code, so the zero-byte, one-byte and many-byte cases and remote frames with non-zero length codes can all be reached. Random frames are derived from the programmed code with occasional single-bit flips. Matching and near-miss frames are therefore both frequent, and every position of all four bytes sees mismatches under both mask settings.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

   localparam int unsigned FILT_BYTES  = 4;
   localparam int unsigned FILT_BYTE_W = 8;
   localparam int unsigned STD_ID_W    = 11;
   localparam int unsigned LEN_W       = 4;

   typedef enum logic {
      BANK_CODE = 1'b0,
      BANK_MASK = 1'b1
   } filt_bank_e;

endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
   import can_filt_pkg::*;
#(
   parameter int unsigned BYTE_W    = FILT_BYTE_W,
   parameter int unsigned NUM_BYTES = FILT_BYTES,
   parameter int unsigned ADDR_W    = $clog2(NUM_BYTES) + 1,
   parameter bit          MASK_PASS = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_mode,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [BYTE_W-1:0]             wr_data,
   output logic [NUM_BYTES*BYTE_W-1:0]   code_o,
   output logic [NUM_BYTES*BYTE_W-1:0]   mask_o
);

   localparam int unsigned IDX_W = $clog2(NUM_BYTES);

   if (ADDR_W != IDX_W + 1) begin : g_bad_addr
      $error("can_filt_regs: ADDR_W must be one bank bit plus the byte index");
   end

   logic [BYTE_W-1:0] mask_rst;
   filt_bank_e        bank;
   logic [IDX_W-1:0]  idx;
   logic              wr_ok;

   if (MASK_PASS) begin : g_rst_pass
      assign mask_rst = '1;
   end else begin : g_rst_block
      assign mask_rst = '0;
   end

   assign bank  = filt_bank_e'(wr_addr[ADDR_W-1]);
   assign idx   = wr_addr[IDX_W-1:0];
   assign wr_ok = cfg_mode & wr_en;

   for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
      localparam logic [IDX_W-1:0] KIDX = IDX_W'(k);
      logic [BYTE_W-1:0] code_q;
      logic [BYTE_W-1:0] mask_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            code_q <= '0;
            mask_q <= mask_rst;
         end else if (wr_ok && (idx == KIDX)) begin
            if (bank == BANK_CODE) begin
               code_q <= wr_data;
            end else begin
               mask_q <= wr_data;
            end
         end
      end

      assign code_o[k*BYTE_W +: BYTE_W] = code_q;
      assign mask_o[k*BYTE_W +: BYTE_W] = mask_q;
   end

   // R3
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |=> ($stable(code_o) && $stable(mask_o)));

endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
   import can_filt_pkg::*;
#(
   parameter int unsigned BYTE_W    = FILT_BYTE_W,
   parameter int unsigned NUM_BYTES = FILT_BYTES,
   parameter int unsigned ID_W      = STD_ID_W,
   parameter int unsigned DLC_W     = LEN_W
) (
   input  logic [NUM_BYTES*BYTE_W-1:0]     code_i,
   input  logic [NUM_BYTES*BYTE_W-1:0]     mask_i,
   input  logic [ID_W-1:0]                 rx_id,
   input  logic                            rx_rtr,
   input  logic [DLC_W-1:0]                rx_dlc,
   input  logic [(NUM_BYTES-2)*BYTE_W-1:0] rx_data,
   output logic                            hit
);

   localparam int unsigned ID_LO_W = ID_W - BYTE_W;
   localparam int unsigned PAD_W   = BYTE_W - ID_LO_W - 1;

   if (ID_W <= BYTE_W || PAD_W < 1) begin : g_bad_id
      $error("can_filt_match: identifier must span byte 0 and part of byte 1");
   end
   if (NUM_BYTES < 3) begin : g_bad_bytes
      $error("can_filt_match: at least one data byte position is needed");
   end

   logic [NUM_BYTES-1:0] byte_ok;

   for (genvar k = 0; k < NUM_BYTES; k++) begin : g_cmp
      logic [BYTE_W-1:0] rx_b;
      logic [BYTE_W-1:0] care_b;
      logic [BYTE_W-1:0] code_b;
      logic [BYTE_W-1:0] mask_b;

      assign code_b = code_i[k*BYTE_W +: BYTE_W];
      assign mask_b = mask_i[k*BYTE_W +: BYTE_W];

      if (k == 0) begin : g_id_hi
         assign rx_b   = rx_id[ID_W-1 -: BYTE_W];
         assign care_b = '1;
      end else if (k == 1) begin : g_id_lo
         assign rx_b   = {rx_id[ID_LO_W-1:0], rx_rtr, {PAD_W{1'b0}}};
         assign care_b = {{(ID_LO_W+1){1'b1}}, {PAD_W{1'b0}}};
      end else begin : g_data
         localparam logic [DLC_W-1:0] NEED = DLC_W'(k - 1);
         logic present;
         assign present = !rx_rtr && (rx_dlc >= NEED);
         assign rx_b    = rx_data[(k-2)*BYTE_W +: BYTE_W];
         assign care_b  = {BYTE_W{present}};
      end

      assign byte_ok[k] = ~|((rx_b ^ code_b) & care_b & ~mask_b);
   end

   assign hit = &byte_ok;

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
   import can_filt_pkg::*;
#(
   parameter int unsigned BYTE_W    = FILT_BYTE_W,
   parameter int unsigned NUM_BYTES = FILT_BYTES,
   parameter int unsigned ID_W      = STD_ID_W,
   parameter int unsigned DLC_W     = LEN_W,
   parameter bit          MASK_PASS = 1'b1,
   parameter int unsigned ADDR_W    = $clog2(NUM_BYTES) + 1,
   parameter int unsigned DATA_W    = (NUM_BYTES - 2) * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [ID_W-1:0]   rx_id,
   input  logic              rx_rtr,
   input  logic [DLC_W-1:0]  rx_dlc,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              hdr_done,
   output logic              accept
);

   localparam int unsigned VEC_W = NUM_BYTES * BYTE_W;

   if (DATA_W != (NUM_BYTES - 2) * BYTE_W) begin : g_bad_data
      $error("can_accept_filter: DATA_W must cover the data byte positions");
   end

   logic [VEC_W-1:0] code_w;
   logic [VEC_W-1:0] mask_w;
   logic             hit;
   logic             accept_q;

   can_filt_regs #(
      .BYTE_W    (BYTE_W),
      .NUM_BYTES (NUM_BYTES),
      .ADDR_W    (ADDR_W),
      .MASK_PASS (MASK_PASS)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_mode (cfg_mode),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .code_o   (code_w),
      .mask_o   (mask_w)
   );

   can_filt_match #(
      .BYTE_W    (BYTE_W),
      .NUM_BYTES (NUM_BYTES),
      .ID_W      (ID_W),
      .DLC_W     (DLC_W)
   ) i_match (
      .code_i  (code_w),
      .mask_i  (mask_w),
      .rx_id   (rx_id),
      .rx_rtr  (rx_rtr),
      .rx_dlc  (rx_dlc),
      .rx_data (rx_data),
      .hit     (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         accept_q <= 1'b0;
      end else begin
         accept_q <= hdr_done & hit;
      end
   end

   assign accept = accept_q;

   // R9
   pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> $past(hdr_done));

   // R10
   pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_done && (&mask_w)) |=> accept);

   // R5
   id_hi_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_done && (((rx_id[ID_W-1 -: BYTE_W] ^ code_w[BYTE_W-1:0])
                     & ~mask_w[BYTE_W-1:0]) != '0)) |=> !accept);

   // R1
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !accept);

endmodule

// File: tb/test_can_accept_filter.sv
module test_can_accept_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mode = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [10:0] rx_id = '0;
   logic        rx_rtr = 1'b0;
   logic [3:0]  rx_dlc = '0;
   logic [15:0] rx_data = '0;
   logic        hdr_done = 1'b0;
   logic        accept;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [7:0] m_code [4];
   logic [7:0] m_mask [4];

   always #10 clk = ~clk;

   can_accept_filter i_can_accept_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_mode (cfg_mode),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rx_id    (rx_id),
      .rx_rtr   (rx_rtr),
      .rx_dlc   (rx_dlc),
      .rx_data  (rx_data),
      .hdr_done (hdr_done),
      .accept   (accept)
   );

   function automatic bit exp_pass(logic [10:0] id, logic rtr, logic [3:0] dlc,
                                   logic [15:0] data);
      logic [7:0] rx [4];
      logic [7:0] care [4];
      bit ok = 1'b1;
      rx[0] = id[10:3];             care[0] = 8'hFF;
      rx[1] = {id[2:0], rtr, 4'h0}; care[1] = 8'hF0;
      rx[2] = data[7:0];            care[2] = (!rtr && dlc >= 1) ? 8'hFF : 8'h00;
      rx[3] = data[15:8];           care[3] = (!rtr && dlc >= 2) ? 8'hFF : 8'h00;
      for (int k = 0; k < 4; k++) begin
         if (((rx[k] ^ m_code[k]) & care[k] & ~m_mask[k]) != 8'h00) ok = 1'b0;
      end
      return ok;
   endfunction

   task automatic check(input bit act, input bit exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic wr(input bit bank, input int idx, input logic [7:0] val, input bit mode);
      @(negedge clk);
      cfg_mode = mode;
      wr_en    = 1'b1;
      wr_addr  = {bank, 2'(idx)};
      wr_data  = val;
      @(negedge clk);
      wr_en    = 1'b0;
      cfg_mode = 1'b0;
      if (mode) begin
         if (bank) m_mask[idx] = val;
         else      m_code[idx] = val;
      end
   endtask

   task automatic frame(input logic [10:0] id, input logic rtr, input logic [3:0] dlc,
                        input logic [15:0] data, input string req);
      bit e;
      e = exp_pass(id, rtr, dlc, data);
      @(negedge clk);
      rx_id = id; rx_rtr = rtr; rx_dlc = dlc; rx_data = data;
      hdr_done = 1'b1;
      @(negedge clk);
      hdr_done = 1'b0;
      check(accept, e, req);
      @(negedge clk);
      check(accept, 1'b0, "R9 pulse width");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [10:0] id;
      logic        rtr;
      logic [3:0]  dlc;
      logic [15:0] data;
      void'($urandom(32'd4417));
      for (int k = 0; k < 4; k++) begin
         m_code[k] = 8'h00;
         m_mask[k] = 8'hFF;
      end

      // R1: reset quiet, with strobes arriving during reset
      repeat (2) @(negedge clk);
      hdr_done = 1'b1;
      @(negedge clk);
      check(accept, 1'b0, "R1 accept in reset");
      hdr_done = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(accept, 1'b0, "R1 accept after reset");

      // R1 / R10: pass-all after reset
      for (int i = 0; i < 20; i++) begin
         frame(11'($urandom), 1'($urandom), 4'($urandom), 16'($urandom), "R1 R10 reset pass-all");
      end

      // R2 / R5 / R6: identifier 0x001, remote bit ignored with mask byte 1 = 0x1F
      wr(0, 0, 8'h00, 1); wr(0, 1, 8'h2F, 1); wr(0, 2, 8'hFF, 1); wr(0, 3, 8'hFF, 1);
      wr(1, 0, 8'h00, 1); wr(1, 1, 8'h1F, 1); wr(1, 2, 8'hFF, 1); wr(1, 3, 8'hFF, 1);
      frame(11'h001, 1'b0, 4'd8, 16'h1234, "R5 R2 exact id");
      frame(11'h001, 1'b1, 4'd0, 16'h0000, "R6 rtr ignored");
      frame(11'h002, 1'b0, 4'd8, 16'h1234, "R5 low id bit");
      frame(11'h401, 1'b0, 4'd8, 16'h1234, "R5 top id bit");

      // R6: remote bit compared when its mask bit is zero; low nibble never compared
      wr(1, 1, 8'h0F, 1);
      frame(11'h001, 1'b1, 4'd0, 16'h0000, "R6 rtr compared");
      frame(11'h001, 1'b0, 4'd0, 16'h0000, "R6 rtr equal");
      wr(1, 1, 8'h00, 1);
      frame(11'h001, 1'b0, 4'd0, 16'h0000, "R6 low nibble unused");

      // R3: write outside configuration mode has no effect
      wr(0, 0, 8'hFF, 0);
      wr(1, 0, 8'hFF, 0);
      frame(11'h001, 1'b0, 4'd0, 16'h0000, "R3 ignored write keeps code");
      frame(11'h7F9, 1'b0, 4'd0, 16'h0000, "R3 ignored write keeps mask");

      // R7 / R8: data byte comparison and missing bytes
      wr(0, 2, 8'hA5, 1); wr(0, 3, 8'h3C, 1);
      wr(1, 2, 8'h00, 1); wr(1, 3, 8'h00, 1);
      frame(11'h001, 1'b0, 4'd2, 16'h3CA5, "R7 both bytes match");
      frame(11'h001, 1'b0, 4'd2, 16'h3CA4, "R7 first byte miss");
      frame(11'h001, 1'b0, 4'd8, 16'hBCA5, "R7 second byte miss");
      frame(11'h001, 1'b0, 4'd1, 16'h00A5, "R8 dlc1 second ignored");
      frame(11'h001, 1'b0, 4'd1, 16'h00A4, "R8 dlc1 first compared");
      frame(11'h001, 1'b0, 4'd0, 16'h0000, "R8 dlc0 both ignored");
      wr(1, 1, 8'h1F, 1);
      frame(11'h001, 1'b1, 4'd8, 16'h0000, "R8 remote frame data ignored");

      // R4: random patterns, frames derived from the code with occasional flips
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 8) == 0) begin
            wr(1'($urandom), int'($urandom % 4), 8'($urandom & $urandom), 1);
         end
         id   = {m_code[0], m_code[1][7:5]};
         rtr  = m_code[1][4];
         data = {m_code[3], m_code[2]};
         dlc  = 4'($urandom);
         if ($urandom % 2) begin
            int b;
            b = int'($urandom % 28);
            if (b < 11)       id[b]      = ~id[b];
            else if (b == 11) rtr        = ~rtr;
            else              data[b-12] = ~data[b-12];
         end
         frame(id, rtr, dlc, data, "R4 random compare");
      end

      // R10: all masks set, code arbitrary
      for (int k = 0; k < 4; k++) begin
         wr(0, k, 8'($urandom), 1);
         wr(1, k, 8'hFF, 1);
      end
      for (int i = 0; i < 10; i++) begin
         frame(11'($urandom), 1'($urandom), 4'($urandom), 16'($urandom), "R10 pass-all");
      end

      // R9: no strobe, no pulse
      repeat (3) begin
         @(negedge clk);
         check(accept, 1'b0, "R9 idle");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule